// File: doc/BRIEF.md
# Serial Nibble Display-Memory Port

This block is a three-wire serial slave that lets a host controller fill and inspect a 128-location, 4-bit-wide display memory. The host frames each transfer with an active-low select. It clocks bits in with an active-low write strobe and clocks bits out with an active-low read strobe. The data line is split into an input, an output and an output enable, which the pad ring combines. Every transfer starts with a three-bit mode code. A memory access then carries a seven-bit start location and one or more nibbles. A control transfer carries one or more nine-bit words.

Memory accesses run as bursts: each finished nibble moves the location counter on by one, and the counter wraps at the top of the memory. A combined mode reads a nibble out and writes a new value into the same location before the counter moves on. Control words are not interpreted here. Each completed word is presented for one system clock together with a valid strobe, for a separate control block to consume. All pad inputs are sampled in the system clock domain through two-flop synchronisers. Edges are found there, so the host must hold each level for several system clocks.

Top module: `dispram_serial_port`

## Requirements
- R1: After reset the output enable and the command valid strobe are low, and every memory location reads back as 0.
- R2: The first three bits after select are the mode code, most significant first: 110 reads, 101 writes (or reads then writes), 100 carries control words. Any other code makes the port ignore all further strobes until select is released: no memory location changes and no command word is produced.
- R3: Serial input bits are taken on rising edges of the write strobe. The seven location bits arrive highest bit first, and each data nibble arrives bit 0 first through bit 3.
- R4: In a write burst the location advances by one after every fourth data bit, and it wraps from 127 to 0.
- R5: In read mode, each falling edge of the read strobe places the next bit of the current location on the output, bit 0 first. After bit 3 the location advances, wrapping from 127 to 0.
- R6: Under code 101, read strobes issued before any write bit of a nibble present that location's stored bits 0 to 3. The next four write bits then replace the same location, and only then does the location advance.
- R7: Under code 100, each group of nine write bits (bit 8 first) is presented on the command output with a one-clock valid pulse. Further groups follow without a new code until select rises. Read strobes have no effect in this mode, and the output enable stays low.
- R8: Raising select abandons the transfer. A partly shifted nibble is not written, a partly shifted command word is not issued, and the next selected transfer is decoded from a fresh mode code.
- R9: The output enable rises only when a read bit is presented. It falls on a falling write-strobe edge and whenever select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Transfer select from the host, active low, asynchronous |
| wstb_n | input | 1 | Write strobe, bits captured on its rising edge, asynchronous |
| rstb_n | input | 1 | Read strobe, bits presented after its falling edge, asynchronous |
| sdata_in | input | 1 | Serial data from the pad |
| sdata_out | output | 1 | Serial data toward the pad |
| sdata_oe | output | 1 | Pad output enable for sdata_out |
| cmd_word | output | 9 | Last completed control word |
| cmd_valid | output | 1 | One-clock strobe marking a new cmd_word |

## Verification
The hardest state to reach from the ports is the combined read-then-write sequence. It interleaves the two strobes on one location, and the location must not move until the write half is finished. The stimulus preloads two neighbouring locations with distinct values and runs one combined burst across both. It checks the read-out of the second location, which shows the counter held and then advanced, and it checks that the output enable dropped once writing began. Select is also raised in the middle of a nibble and in the middle of a control word. The bench then shows, through a later read and the command strobe count, that nothing partial was committed.

// File: rtl/dispram_pkg.sv
// Shared codes and state types for the serial display-memory port.
// Assumes a three-bit mode code, sent most significant bit first.
package dispram_pkg;

    localparam int         MODE_W    = 3;
    localparam logic [2:0] MODE_READ = 3'b110;
    localparam logic [2:0] MODE_WRT  = 3'b101;
    localparam logic [2:0] MODE_CTRL = 3'b100;

    typedef enum logic [2:0] {
        PH_MODE,
        PH_LOC,
        PH_DATA,
        PH_CTRL,
        PH_IGNORE
    } phase_t;

    typedef enum logic {
        AC_READ,
        AC_WRITE
    } access_t;

endpackage

// File: rtl/dispram_sync.sv
// Synchroniser for one asynchronous pad level, plus one history flop.
// Assumes the pad idles at RST_VAL; `level` is the synchronised value and
// `prev` is the same value one clock older, for edge detection downstream.
module dispram_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic prev
);

    logic [STAGES:0] pipe;

    // Shift the pad value through the synchroniser and history flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= {(STAGES + 1){RST_VAL}};
        end else begin
            pipe <= (STAGES + 1)'({pipe, async_in});
        end
    end

    assign level = pipe[STAGES-1];
    assign prev  = pipe[STAGES];

endmodule

// File: rtl/dispram_store.sv
// Display memory: 2**ADDR_W words of DATA_W bits, one synchronous write
// port and one combinational read port. Reset clears every word.
module dispram_store #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Clear on reset, otherwise commit a write request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // A write request lands in the addressed word on the next clock.
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata))
        else $error("write request did not reach memory");

endmodule

// File: rtl/dispram_seq.sv
// Bit sequencer of the serial port. Works on edge pulses that are already
// in the clk domain. Decodes the mode code, shifts in the start location,
// runs read, write, read-then-write and control bursts, and drives the
// output bit and its enable. Assumes at most one strobe edge per clock.
module dispram_seq
    import dispram_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 4,
    parameter int CMD_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_idle,
    input  logic              wr_rise,
    input  logic              wr_fall,
    input  logic              rd_fall,
    input  logic              din,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_waddr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [ADDR_W-1:0] ram_raddr,
    output logic              data_out,
    output logic              data_oe,
    output logic [CMD_W-1:0]  cmd_word,
    output logic              cmd_valid
);

    localparam int CNT_MAX = (CMD_W > ADDR_W) ? CMD_W : ADDR_W;
    localparam int CNT_W   = $clog2(CNT_MAX);
    localparam int SH_W    = CMD_W - 1;
    localparam int BIT_W   = $clog2(DATA_W);
    localparam int RDC_W   = BIT_W + 1;

    localparam logic [CNT_W-1:0] MODE_LAST = CNT_W'(MODE_W - 1);
    localparam logic [CNT_W-1:0] LOC_LAST  = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] NIB_LAST  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [RDC_W-1:0] RD_LAST   = RDC_W'(DATA_W - 1);
    localparam logic [RDC_W-1:0] RD_DONE   = RDC_W'(DATA_W);

    phase_t              phase;
    access_t             access;
    logic [CNT_W-1:0]    bit_cnt;
    logic [RDC_W-1:0]    rd_cnt;
    logic [SH_W-1:0]     shreg;
    logic [DATA_W-2:0]   wnib;
    logic [ADDR_W-1:0]   loc;
    logic [MODE_W-1:0]   mode_code;

    assign mode_code = {shreg[MODE_W-2:0], din};
    assign ram_raddr = loc;

    // Sequence the transfer: one branch per phase, select high aborts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_MODE;
            access    <= AC_READ;
            bit_cnt   <= '0;
            rd_cnt    <= '0;
            shreg     <= '0;
            wnib      <= '0;
            loc       <= '0;
            ram_we    <= 1'b0;
            ram_waddr <= '0;
            ram_wdata <= '0;
            data_out  <= 1'b0;
            data_oe   <= 1'b0;
            cmd_word  <= '0;
            cmd_valid <= 1'b0;
        end else begin
            ram_we    <= 1'b0;
            cmd_valid <= 1'b0;
            if (sel_idle) begin
                phase   <= PH_MODE;
                bit_cnt <= '0;
                rd_cnt  <= '0;
                data_oe <= 1'b0;
            end else begin
                if (wr_fall) begin
                    data_oe <= 1'b0;
                end
                unique case (phase)
                    PH_MODE: begin
                        if (wr_rise) begin
                            shreg <= {shreg[SH_W-2:0], din};
                            if (bit_cnt == MODE_LAST) begin
                                bit_cnt <= '0;
                                if (mode_code == MODE_READ) begin
                                    access <= AC_READ;
                                    phase  <= PH_LOC;
                                end else if (mode_code == MODE_WRT) begin
                                    access <= AC_WRITE;
                                    phase  <= PH_LOC;
                                end else if (mode_code == MODE_CTRL) begin
                                    phase  <= PH_CTRL;
                                end else begin
                                    phase  <= PH_IGNORE;
                                end
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    PH_LOC: begin
                        if (wr_rise) begin
                            shreg <= {shreg[SH_W-2:0], din};
                            if (bit_cnt == LOC_LAST) begin
                                loc     <= {shreg[ADDR_W-2:0], din};
                                bit_cnt <= '0;
                                rd_cnt  <= '0;
                                phase   <= PH_DATA;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    PH_DATA: begin
                        if (access == AC_WRITE && wr_rise) begin
                            if (bit_cnt == NIB_LAST) begin
                                ram_we    <= 1'b1;
                                ram_waddr <= loc;
                                ram_wdata <= {din, wnib};
                                loc       <= loc + 1'b1;
                                bit_cnt   <= '0;
                                rd_cnt    <= '0;
                            end else begin
                                wnib[bit_cnt[BIT_W-1:0]] <= din;
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end else if (rd_fall) begin
                            if (access == AC_READ) begin
                                data_out <= ram_rdata[rd_cnt[BIT_W-1:0]];
                                data_oe  <= 1'b1;
                                if (rd_cnt == RD_LAST) begin
                                    rd_cnt <= '0;
                                    loc    <= loc + 1'b1;
                                end else begin
                                    rd_cnt <= rd_cnt + 1'b1;
                                end
                            end else if (bit_cnt == '0 && rd_cnt != RD_DONE) begin
                                data_out <= ram_rdata[rd_cnt[BIT_W-1:0]];
                                data_oe  <= 1'b1;
                                rd_cnt   <= rd_cnt + 1'b1;
                            end
                        end
                    end
                    PH_CTRL: begin
                        if (wr_rise) begin
                            shreg <= {shreg[SH_W-2:0], din};
                            if (bit_cnt == CMD_LAST) begin
                                cmd_word  <= {shreg, din};
                                cmd_valid <= 1'b1;
                                bit_cnt   <= '0;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    // Released select always pulls the data pad enable low.
    assert_oe_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_idle |=> !data_oe)
        else $error("output enable held while deselected");

    // The output enable only turns on in answer to a read strobe edge.
    assert_oe_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_oe) |-> $past(rd_fall))
        else $error("output enable rose without a read strobe");

    // Each committed nibble is followed by the next location.
    assert_loc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> loc == ram_waddr + 1'b1)
        else $error("location did not advance after a nibble");

    // A control word is announced for exactly one clock.
    assert_cmd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid)
        else $error("command strobe longer than one clock");

    // An unknown mode code produces neither writes nor control words.
    assert_ignore_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IGNORE && $past(phase) == PH_IGNORE) |-> !ram_we && !cmd_valid)
        else $error("activity after an unknown mode code");

endmodule

// File: rtl/dispram_serial_port.sv
// Top of the serial display-memory port. Synchronises the select, strobes
// and data pad into clk, derives strobe edges and ties the sequencer to the
// memory. Assumes each pad level is held for at least four clk periods.
module dispram_serial_port #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 4,
    parameter int CMD_W       = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             wstb_n,
    input  logic             rstb_n,
    input  logic             sdata_in,
    output logic             sdata_out,
    output logic             sdata_oe,
    output logic [CMD_W-1:0] cmd_word,
    output logic             cmd_valid
);

    logic sel_lvl, sel_prev, wr_lvl, wr_prev, rd_lvl, rd_prev;
    logic sel_idle, wr_rise, wr_fall, rd_fall;
    logic [SYNC_STAGES-1:0] din_pipe;
    logic                   ram_we;
    logic [ADDR_W-1:0]      ram_waddr, ram_raddr;
    logic [DATA_W-1:0]      ram_wdata, ram_rdata;

    dispram_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sel_n), .level(sel_lvl), .prev(sel_prev));
    dispram_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wr_sync (
        .clk(clk), .rst_n(rst_n), .async_in(wstb_n), .level(wr_lvl), .prev(wr_prev));
    dispram_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rd_sync (
        .clk(clk), .rst_n(rst_n), .async_in(rstb_n), .level(rd_lvl), .prev(rd_prev));

    // Carry the data pad through the same depth as the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_pipe <= '1;
        end else begin
            din_pipe <= SYNC_STAGES'({din_pipe, sdata_in});
        end
    end

    assign sel_idle = sel_lvl | sel_prev;
    assign wr_rise  = wr_lvl & ~wr_prev;
    assign wr_fall  = ~wr_lvl & wr_prev;
    assign rd_fall  = ~rd_lvl & rd_prev;

    dispram_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_idle  (sel_idle),
        .wr_rise   (wr_rise),
        .wr_fall   (wr_fall),
        .rd_fall   (rd_fall),
        .din       (din_pipe[SYNC_STAGES-1]),
        .ram_rdata (ram_rdata),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_wdata (ram_wdata),
        .ram_raddr (ram_raddr),
        .data_out  (sdata_out),
        .data_oe   (sdata_oe),
        .cmd_word  (cmd_word),
        .cmd_valid (cmd_valid)
    );

    dispram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    // A write edge and a read edge never act in the same clock.
    assert_one_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_rise && rd_fall))
        else $error("simultaneous strobe edges");

endmodule

// File: tb/dispram_serial_port_bench.sv
// Directed bench for the serial display-memory port, one task per scenario.
module dispram_serial_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b1;
    logic       wstb_n = 1'b1;
    logic       rstb_n = 1'b1;
    logic       sdata_in = 1'b1;
    logic       sdata_out, sdata_oe, cmd_valid;
    logic [8:0] cmd_word;

    int checks = 0;
    int failures = 0;
    int cmd_cnt = 0;
    logic [8:0] last_cmd = '0;

    always #10 clk = ~clk;

    dispram_serial_port u_dispram_serial_port (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wstb_n(wstb_n), .rstb_n(rstb_n),
        .sdata_in(sdata_in), .sdata_out(sdata_out), .sdata_oe(sdata_oe),
        .cmd_word(cmd_word), .cmd_valid(cmd_valid));

    // Record every command strobe seen at the ports.
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            cmd_cnt  = cmd_cnt + 1;
            last_cmd = cmd_word;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sel();
        sel_n = 1'b0;
        tick(8);
    endtask

    task automatic desel();
        sel_n = 1'b1; wstb_n = 1'b1; rstb_n = 1'b1;
        tick(8);
    endtask

    task automatic put_bit(input logic b);
        sdata_in = b; tick(2);
        wstb_n = 1'b0; tick(6);
        wstb_n = 1'b1; tick(6);
    endtask

    task automatic put_mode(input logic [2:0] m);
        for (int i = 2; i >= 0; i--) put_bit(m[i]);
    endtask

    task automatic put_loc(input logic [6:0] a);
        for (int i = 6; i >= 0; i--) put_bit(a[i]);
    endtask

    task automatic put_nib(input logic [3:0] d);
        for (int i = 0; i < 4; i++) put_bit(d[i]);
    endtask

    task automatic put_cmd(input logic [8:0] c);
        for (int i = 8; i >= 0; i--) put_bit(c[i]);
    endtask

    task automatic get_nib(output logic [3:0] d, output logic oe_all);
        oe_all = 1'b1;
        for (int i = 0; i < 4; i++) begin
            rstb_n = 1'b0; tick(6);
            d[i] = sdata_out;
            oe_all = oe_all & sdata_oe;
            rstb_n = 1'b1; tick(6);
        end
    endtask

    task automatic read_at(input logic [6:0] a, output logic [3:0] d);
        logic oe;
        sel(); put_mode(3'b110); put_loc(a); get_nib(d, oe); desel();
    endtask

    task automatic write_at(input logic [6:0] a, input logic [3:0] d);
        sel(); put_mode(3'b101); put_loc(a); put_nib(d); desel();
    endtask

    task automatic t_reset();
        logic [3:0] d;
        chk("R1 oe after reset", sdata_oe, 0);
        chk("R1 cmd_valid after reset", cmd_valid, 0);
        read_at(7'd0, d);   chk("R1 location 0 cleared", d, 0);
        read_at(7'd127, d); chk("R1 location 127 cleared", d, 0);
    endtask

    task automatic t_write_read();
        logic [3:0] d;
        logic oe;
        write_at(7'd5, 4'h1);
        sel(); put_mode(3'b110); put_loc(7'd4);
        get_nib(d, oe); chk("R3 neighbour 4 untouched", d, 0);
        get_nib(d, oe); chk("R3 location 5 bit order", d, 4'h1);
        chk("R9 oe during read bits", oe, 1);
        get_nib(d, oe); chk("R5 neighbour 6 untouched", d, 0);
        desel();
        chk("R9 oe low after deselect", sdata_oe, 0);
        read_at(7'd80, d); chk("R3 location sent high bit first", d, 0);
    endtask

    task automatic t_burst_wrap();
        logic [3:0] d;
        logic oe;
        sel(); put_mode(3'b101); put_loc(7'd126);
        put_nib(4'hD); put_nib(4'h6); put_nib(4'h3); desel();
        read_at(7'd0, d); chk("R4 write wrap to 0", d, 4'h3);
        sel(); put_mode(3'b110); put_loc(7'd126);
        get_nib(d, oe); chk("R5 burst 126", d, 4'hD);
        get_nib(d, oe); chk("R5 burst 127", d, 4'h6);
        get_nib(d, oe); chk("R5 read wrap to 0", d, 4'h3);
        desel();
    endtask

    task automatic t_rmw();
        logic [3:0] d;
        logic oe;
        sel(); put_mode(3'b101); put_loc(7'd20); put_nib(4'h7); put_nib(4'h9); desel();
        sel(); put_mode(3'b101); put_loc(7'd20);
        get_nib(d, oe); chk("R6 read-out of 20", d, 4'h7);
        chk("R9 oe in read half", oe, 1);
        put_nib(4'h1);
        chk("R9 oe dropped by write strobe", sdata_oe, 0);
        get_nib(d, oe); chk("R6 read-out of 21 after advance", d, 4'h9);
        put_nib(4'hE);
        desel();
        read_at(7'd20, d); chk("R6 new value at 20", d, 4'h1);
        read_at(7'd21, d); chk("R6 new value at 21", d, 4'hE);
    endtask

    task automatic t_cmd();
        int base;
        base = cmd_cnt;
        sel(); put_mode(3'b100);
        put_cmd(9'h1A5);
        chk("R7 first word count", cmd_cnt - base, 1);
        chk("R7 first word value", last_cmd, 9'h1A5);
        rstb_n = 1'b0; tick(6);
        chk("R7 read strobe leaves oe low", sdata_oe, 0);
        rstb_n = 1'b1; tick(6);
        put_cmd(9'h003);
        chk("R7 second word without code", cmd_cnt - base, 2);
        chk("R7 second word value", last_cmd, 9'h003);
        desel();
    endtask

    task automatic t_abort();
        logic [3:0] d;
        int base;
        sel(); put_mode(3'b101); put_loc(7'd30); put_bit(1'b1); put_bit(1'b1); desel();
        read_at(7'd30, d); chk("R8 partial nibble dropped", d, 0);
        base = cmd_cnt;
        sel(); put_mode(3'b100);
        for (int i = 0; i < 5; i++) put_bit(1'b1);
        desel();
        chk("R8 partial word dropped", cmd_cnt - base, 0);
        sel(); put_mode(3'b100); put_cmd(9'h0F0); desel();
        chk("R8 fresh code after reselect", cmd_cnt - base, 1);
        chk("R8 fresh word value", last_cmd, 9'h0F0);
    endtask

    task automatic t_bad_mode();
        logic [3:0] d;
        int base;
        base = cmd_cnt;
        sel(); put_mode(3'b111); put_loc(7'd40); put_nib(4'hC);
        for (int i = 0; i < 9; i++) put_bit(1'b0);
        desel();
        read_at(7'd40, d); chk("R2 unknown code writes nothing", d, 0);
        chk("R2 unknown code issues no word", cmd_cnt - base, 0);
    endtask

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(4);
        t_reset();
        t_write_read();
        t_burst_wrap();
        t_rmw();
        t_cmd();
        t_abort();
        t_bad_mode();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule